// File: doc/BRIEF.md
# Multiport Repeater Arbitration Controller

This block is the decision-making part of a half-duplex repeater core with a parameterised number of ports (eight by default). On every clock it reads each port's carrier-sense and receive-data-valid lines, along with per-port flags that mark a port as jabbered or isolated. From these it works out the repeater's activity mode. It then drives per-port transmit and receive enables, a select that picks either forwarded data or the jam fill, the fill nibble itself, and the index of the port whose data is being forwarded.

The controller has four modes. In idle, nothing is happening. In forwarding, exactly one port is heard and its data goes to every other port. In collision, several ports are active at once, or a lone carrier has stayed silent too long, and every port is jammed. In last-port, a collision is winding down and one port still holds carrier; every port except that one is jammed.

All outputs come from registered mode state, so they follow the inputs by one clock. The one exception is the jabber/isolation masking, which applies combinationally. The moving of nibble data itself is left to a separate datapath.

Top module: `rpt_arbiter`

## Requirements
- R1: While reset is held, and on any clock after a cycle in which no port had carrier, mode_o is 0 (idle) and tx_en_o, rx_en_o, jam_sel_o and fill_nib_o are all zero.
- R2: When exactly one port (index k) has carrier, the next cycle shows mode_o = 1 (forwarding) and src_idx_o = k. tx_en_o is set for every port except k, rx_en_o has only bit k set, and jam_sel_o is 0.
- R3: In every mode, a port whose jab_i or iso_i bit is high has its tx_en_o and rx_en_o bits low.
- R4: When two or more ports have carrier on the same clock, the next cycle shows mode_o = 2 (collision). tx_en_o is set for all ports, rx_en_o is zero, jam_sel_o is 1 and fill_nib_o is 4'h5.
- R5: A lone carrier that comes with no receive-data-valid on any active port for five consecutive clocks (more than 4) causes collision on the fifth clock. Any clock with data-valid restarts that count.
- R6: When collision falls to exactly one carrier, the next cycle shows mode_o = 3 (last-port). tx_en_o is set for all ports except the remaining one, rx_en_o is zero and jam_sel_o is 1.
- R7: Collision persists for as long as two or more ports keep carrier.
- R8: From last-port, the mode returns to idle once no carrier remains, and returns to collision if two or more carriers appear.
- R9: src_idx_o reads 0 in every mode other than forwarding.
- R10: From forwarding, the arrival of a second carrier causes collision on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| crs_i | input | 8 | Per-port carrier sense |
| rxdv_i | input | 8 | Per-port receive data valid |
| jab_i | input | 8 | Per-port jabber flag; blocks that port |
| iso_i | input | 8 | Per-port isolation flag; blocks that port |
| tx_en_o | output | 8 | Per-port transmit enable |
| rx_en_o | output | 8 | Per-port receive enable (forwarding source only) |
| jam_sel_o | output | 1 | 1 = drive jam fill, 0 = drive forwarded data |
| fill_nib_o | output | 4 | Jam nibble (4'h5) while jamming, else 0 |
| src_idx_o | output | 3 | Forwarding source port index |
| mode_o | output | 2 | 0 idle, 1 forwarding, 2 collision, 3 last-port |

## Verification
The bench drives several kinds of carrier pattern:
- A single carrier with data-valid asserted at once, which separates plain forwarding from every jam mode.
- Two carriers that rise on the same clock, and a second carrier that joins an ongoing forward; these show whether the collision decision follows the carrier count and not the previous mode.
- A collision that decays to one carrier and then either clears or picks up a new partner, which checks the last-port exits in both directions.
- A silent lone carrier, once broken by a data-valid pulse and once left silent, which pins the timer threshold to the exact clock.

Long random carrier mixes with jabber and isolation flags are then compared each cycle against a behavioural model.

// File: rtl/rpt_arb_pkg.sv
package rpt_arb_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FWD  = 2'd1,
    ST_COLL = 2'd2,
    ST_LAST = 2'd3
  } rpt_state_e;

  localparam logic [3:0] JAM_NIBBLE = 4'h5;

endpackage

// File: rtl/rpt_carrier_scan.sv
module rpt_carrier_scan #(
  parameter int NPORT = 8,
  localparam int IW = $clog2(NPORT)
) (
  input  logic [NPORT-1:0] crs_i,
  input  logic [NPORT-1:0] rxdv_i,
  output logic             any_o,
  output logic             lone_o,
  output logic             multi_o,
  output logic             quiet_o,
  output logic [IW-1:0]    low_idx_o
);

  // seen[p] is high when some port below p has carrier
  logic [NPORT:0]   seen;
  logic [NPORT-1:0] first;
  logic [NPORT-1:0] extra;

  assign seen[0] = 1'b0;

  for (genvar p = 0; p < NPORT; p++) begin : g_scan
    assign seen[p+1] = seen[p] | crs_i[p];
    assign first[p]  = crs_i[p] & ~seen[p];
    assign extra[p]  = crs_i[p] & seen[p];
  end

  always_comb begin
    low_idx_o = '0;
    for (int p = 0; p < NPORT; p++) begin
      if (first[p]) low_idx_o = IW'(p);
    end
  end

  assign any_o   = seen[NPORT];
  assign multi_o = |extra;
  assign lone_o  = any_o & ~multi_o;
  assign quiet_o = ~|(crs_i & rxdv_i);

endmodule

// File: rtl/rpt_quiet_timer.sv
module rpt_quiet_timer #(
  parameter int WAIT = 4,
  localparam int CW = $clog2(WAIT + 2)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic count_en_i,
  output logic expired_o
);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          sat;

  assign sat = (cnt_q >= CW'(WAIT + 1));

  always_comb begin
    if (!count_en_i)  cnt_d = '0;
    else if (sat)     cnt_d = cnt_q;
    else              cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign expired_o = (cnt_q >= CW'(WAIT));

  // R5: the timer only reports expiry after silent clocks were counted
  p_expiry_needs_count_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expired_o |-> $past(count_en_i));

endmodule

// File: rtl/rpt_state_ctl.sv
module rpt_state_ctl
  import rpt_arb_pkg::*;
#(
  parameter int NPORT = 8,
  parameter int WAIT  = 4,
  localparam int IW = $clog2(NPORT)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NPORT-1:0] crs_i,
  input  logic [NPORT-1:0] rxdv_i,
  output rpt_state_e       st_o,
  output logic [IW-1:0]    src_o,
  output logic [NPORT-1:0] surv_o
);

  logic          any_c, lone_c, multi_c, quiet_c;
  logic [IW-1:0] low_c;
  logic          cnt_en, expired;

  rpt_state_e       st_q, st_d;
  logic [IW-1:0]    src_q, src_d;
  logic [NPORT-1:0] surv_q, surv_d;

  rpt_carrier_scan #(.NPORT(NPORT)) u_scan (
    .crs_i     (crs_i),
    .rxdv_i    (rxdv_i),
    .any_o     (any_c),
    .lone_o    (lone_c),
    .multi_o   (multi_c),
    .quiet_o   (quiet_c),
    .low_idx_o (low_c)
  );

  assign cnt_en = lone_c & quiet_c & ((st_q == ST_IDLE) | (st_q == ST_FWD));

  rpt_quiet_timer #(.WAIT(WAIT)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .count_en_i (cnt_en),
    .expired_o  (expired)
  );

  always_comb begin
    st_d = st_q;
    if (!any_c) begin
      st_d = ST_IDLE;
    end else if (multi_c) begin
      st_d = ST_COLL;
    end else begin
      unique case (st_q)
        ST_IDLE, ST_FWD: st_d = (quiet_c && expired) ? ST_COLL : ST_FWD;
        ST_COLL, ST_LAST: st_d = ST_LAST;
        default:          st_d = ST_IDLE;
      endcase
    end
  end

  assign src_d  = (st_d == ST_FWD)  ? low_c : '0;
  assign surv_d = (st_d == ST_LAST) ? crs_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      src_q  <= '0;
      surv_q <= '0;
    end else begin
      st_q   <= st_d;
      src_q  <= src_d;
      surv_q <= surv_d;
    end
  end

  assign st_o   = st_q;
  assign src_o  = src_q;
  assign surv_o = surv_q;

  // R1: a clock with no carrier leads to idle
  p_idle_after_silence_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && ($past(crs_i) == '0)) |-> (st_q == ST_IDLE));

  // R4: two or more carriers lead to collision
  p_multi_gives_coll_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && ($countones($past(crs_i)) > 1)) |-> (st_q == ST_COLL));

  // R2: forwarding only follows a clock with exactly one carrier
  p_fwd_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_FWD) |-> ($countones($past(crs_i)) == 1));

  // R6: last-port is entered only out of a collision
  p_last_from_coll_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_LAST) |-> (($past(st_q) == ST_COLL) || ($past(st_q) == ST_LAST)));

endmodule

// File: rtl/rpt_out_decode.sv
module rpt_out_decode
  import rpt_arb_pkg::*;
#(
  parameter int NPORT = 8,
  localparam int IW = $clog2(NPORT)
) (
  input  rpt_state_e       st_i,
  input  logic [IW-1:0]    src_i,
  input  logic [NPORT-1:0] surv_i,
  input  logic [NPORT-1:0] block_i,
  output logic [NPORT-1:0] tx_en_o,
  output logic [NPORT-1:0] rx_en_o,
  output logic             jam_sel_o,
  output logic [3:0]       fill_nib_o
);

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    localparam logic [IW-1:0] PIDX = IW'(p);
    logic tx_raw;

    always_comb begin
      unique case (st_i)
        ST_FWD:  tx_raw = (src_i != PIDX);
        ST_COLL: tx_raw = 1'b1;
        ST_LAST: tx_raw = ~surv_i[p];
        default: tx_raw = 1'b0;
      endcase
    end

    assign tx_en_o[p] = tx_raw & ~block_i[p];
    assign rx_en_o[p] = (st_i == ST_FWD) & (src_i == PIDX) & ~block_i[p];
  end

  assign jam_sel_o  = (st_i == ST_COLL) | (st_i == ST_LAST);
  assign fill_nib_o = jam_sel_o ? JAM_NIBBLE : 4'h0;

endmodule

// File: rtl/rpt_arbiter.sv
module rpt_arbiter
  import rpt_arb_pkg::*;
#(
  parameter int NPORT = 8,
  parameter int WAIT  = 4,
  localparam int IW = $clog2(NPORT)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NPORT-1:0] crs_i,
  input  logic [NPORT-1:0] rxdv_i,
  input  logic [NPORT-1:0] jab_i,
  input  logic [NPORT-1:0] iso_i,
  output logic [NPORT-1:0] tx_en_o,
  output logic [NPORT-1:0] rx_en_o,
  output logic             jam_sel_o,
  output logic [3:0]       fill_nib_o,
  output logic [IW-1:0]    src_idx_o,
  output logic [1:0]       mode_o
);

  rpt_state_e       st;
  logic [IW-1:0]    src;
  logic [NPORT-1:0] surv;
  logic [NPORT-1:0] block;

  assign block = jab_i | iso_i;

  rpt_state_ctl #(.NPORT(NPORT), .WAIT(WAIT)) u_ctl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .crs_i  (crs_i),
    .rxdv_i (rxdv_i),
    .st_o   (st),
    .src_o  (src),
    .surv_o (surv)
  );

  rpt_out_decode #(.NPORT(NPORT)) u_dec (
    .st_i       (st),
    .src_i      (src),
    .surv_i     (surv),
    .block_i    (block),
    .tx_en_o    (tx_en_o),
    .rx_en_o    (rx_en_o),
    .jam_sel_o  (jam_sel_o),
    .fill_nib_o (fill_nib_o)
  );

  assign src_idx_o = src;
  assign mode_o    = st;

  // R3: blocked ports never get an enable
  p_blocked_silent_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((tx_en_o | rx_en_o) & (jab_i | iso_i)) == '0);

  // R2: the forwarding source never hears its own frame
  p_no_echo_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'd1) |-> !tx_en_o[src_idx_o]);

  // R2: at most one port is received at a time
  p_rx_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(rx_en_o));

  // R6: the remaining port is never jammed in last-port mode
  p_spare_survivor_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'd3) |-> ((tx_en_o & surv) == '0));

  // R9: source index is zero outside forwarding
  p_src_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o != 2'd1) |-> (src_idx_o == '0));

endmodule

// File: tb/rpt_arbiter_tb_top.sv
`timescale 1ns/1ps
module rpt_arbiter_tb_top;

  localparam int NP   = 8;
  localparam int WAIT = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NP-1:0] crs, rxdv, jab, iso;
  logic [NP-1:0] tx_en, rx_en;
  logic          jam_sel;
  logic [3:0]    fill_nib;
  logic [2:0]    src_idx;
  logic [1:0]    mode;

  int checks = 0;
  int fails  = 0;

  // reference model state
  int            m_st, m_src, m_q;
  logic [NP-1:0] m_surv;

  always #2.5 clk = ~clk;

  rpt_arbiter #(.NPORT(NP), .WAIT(WAIT)) dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .crs_i      (crs),
    .rxdv_i     (rxdv),
    .jab_i      (jab),
    .iso_i      (iso),
    .tx_en_o    (tx_en),
    .rx_en_o    (rx_en),
    .jam_sel_o  (jam_sel),
    .fill_nib_o (fill_nib),
    .src_idx_o  (src_idx),
    .mode_o     (mode)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got 0x%0h expected 0x%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic string stag(input int s);
    case (s)
      0: return "R1";
      1: return "R2";
      2: return "R4";
      default: return "R6";
    endcase
  endfunction

  task automatic model_edge();
    int n, lowest, ns;
    bit quiet;
    if (!rst_n) begin
      m_st = 0; m_src = 0; m_q = 0; m_surv = '0;
      return;
    end
    n = $countones(crs);
    quiet = ((crs & rxdv) == '0);
    lowest = 0;
    for (int p = NP - 1; p >= 0; p--) if (crs[p]) lowest = p;
    if (n == 0) ns = 0;
    else if (n >= 2) ns = 2;
    else if (m_st <= 1) ns = (quiet && m_q >= WAIT) ? 2 : 1;
    else ns = 3;
    if (n == 1 && quiet && m_st <= 1) m_q = (m_q >= WAIT + 1) ? m_q : m_q + 1;
    else m_q = 0;
    m_src  = (ns == 1) ? lowest : 0;
    m_surv = (ns == 3) ? crs : '0;
    m_st   = ns;
  endtask

  task automatic compare_all();
    logic [NP-1:0] blk, etx, erx;
    string t;
    blk = jab | iso;
    t = stag(m_st);
    etx = '0; erx = '0;
    case (m_st)
      1: begin etx = ~(NP'(1) << m_src); erx = NP'(1) << m_src; end
      2: etx = '1;
      3: etx = ~m_surv;
      default: ;
    endcase
    etx &= ~blk;
    erx &= ~blk;
    chk(mode == m_st[1:0], t, "mode", mode, m_st);
    chk(tx_en == etx, t, "tx_en", tx_en, etx);
    chk(rx_en == erx, t, "rx_en", rx_en, erx);
    chk(jam_sel == (m_st >= 2), t, "jam_sel", jam_sel, (m_st >= 2));
    chk(fill_nib == ((m_st >= 2) ? 4'h5 : 4'h0), "R4", "fill_nib", fill_nib,
        (m_st >= 2) ? 5 : 0);
    chk(src_idx == m_src[2:0], (m_st == 1) ? "R2" : "R9", "src_idx", src_idx, m_src);
    chk(((tx_en | rx_en) & blk) == '0, "R3", "blocked enable", tx_en | rx_en, 0);
  endtask

  task automatic cycle(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      model_edge();
      @(negedge clk);
      compare_all();
    end
  endtask

  task automatic expect_mode(input int m, input string tag);
    chk(mode == m[1:0], tag, "directed mode", mode, m);
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; crs = '0; rxdv = '0; jab = '0; iso = '0;
    m_st = 0; m_src = 0; m_q = 0; m_surv = '0;
    cycle(3);
    chk(tx_en == '0 && mode == 2'd0, "R1", "reset outputs", tx_en, 0);
    rst_n = 1'b1;
    cycle();
    expect_mode(0, "R1");

    // R2: single source forwards to all others
    crs = 8'h08; rxdv = 8'h08;
    cycle();
    expect_mode(1, "R2");
    chk(src_idx == 3'd3, "R2", "source index", src_idx, 3);
    chk(tx_en == 8'hF7, "R2", "tx fanout", tx_en, 8'hF7);
    cycle(6);
    crs = '0; rxdv = '0;
    cycle();
    expect_mode(0, "R1");
    chk(src_idx == 3'd0, "R9", "idle source index", src_idx, 0);

    // R3: jabber and isolation masks while forwarding
    jab = 8'h20; iso = 8'h04;
    crs = 8'h01; rxdv = 8'h01;
    cycle();
    chk(tx_en == 8'hDA, "R3", "masked fanout", tx_en, 8'hDA);
    cycle(3);
    crs = '0; rxdv = '0;
    cycle(2);
    jab = '0; iso = '0;

    // R4/R7/R6/R8: simultaneous carriers, decay, clear
    crs = 8'h42; rxdv = 8'h42;
    cycle();
    expect_mode(2, "R4");
    chk(fill_nib == 4'h5, "R4", "jam nibble", fill_nib, 5);
    cycle(3);
    expect_mode(2, "R7");
    crs = 8'h02; rxdv = 8'h02;
    cycle();
    expect_mode(3, "R6");
    chk(tx_en == 8'hFD, "R6", "survivor spared", tx_en, 8'hFD);
    crs = '0; rxdv = '0;
    cycle();
    expect_mode(0, "R8");

    // R8: last-port back into collision
    crs = 8'h14; rxdv = 8'h14;
    cycle();
    crs = 8'h04; rxdv = 8'h04;
    cycle();
    expect_mode(3, "R6");
    crs = 8'h84; rxdv = 8'h84;
    cycle();
    expect_mode(2, "R8");
    crs = '0; rxdv = '0;
    cycle();

    // R5: silent lone carrier
    crs = 8'h20; rxdv = '0;
    cycle(4);
    expect_mode(1, "R5");
    rxdv = 8'h20;
    cycle();
    expect_mode(1, "R5");
    rxdv = '0;
    cycle(4);
    expect_mode(1, "R5");
    cycle();
    expect_mode(2, "R5");
    cycle();
    expect_mode(3, "R6");
    crs = '0;
    cycle(2);

    // R10: second carrier joins a forward
    crs = 8'h04; rxdv = 8'h04;
    cycle();
    expect_mode(1, "R2");
    crs = 8'h14; rxdv = 8'h14;
    cycle();
    expect_mode(2, "R10");
    crs = '0; rxdv = '0;
    cycle();

    // R3: masks during collision
    jab = 8'h81;
    crs = 8'h18; rxdv = 8'h18;
    cycle();
    chk(tx_en == 8'h7E, "R3", "masked jam", tx_en, 8'h7E);
    crs = '0; rxdv = '0; jab = '0;
    cycle();

    // random mixes
    for (int k = 0; k < 600; k++) begin
      int r;
      r = $urandom_range(0, 9);
      if (r < 4) ;
      else if (r < 7) crs = NP'(1) << $urandom_range(0, NP - 1);
      else if (r < 8) crs = (NP'(1) << $urandom_range(0, NP - 1)) |
                            (NP'(1) << $urandom_range(0, NP - 1));
      else crs = '0;
      rxdv = ($urandom_range(0, 3) == 0) ? '0 : crs;
      jab  = ($urandom_range(0, 7) == 0) ? NP'($urandom) : '0;
      iso  = ($urandom_range(0, 7) == 0) ? NP'($urandom) : '0;
      cycle();
    end

    crs = '0; rxdv = '0; jab = '0; iso = '0;
    cycle(2);
    expect_mode(0, "R1");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule